// File: doc/BRIEF.md
# Serial Converter Command and Configuration Front End

This block is the serial slave side of a multi-channel converter controller. A host frames each transfer with an active-low select and moves 16-bit words MSB first on a serial clock. The serial pins are brought into the block's system clock domain, and both edges of the serial clock are found there. The top four bits of each frame are an opcode. Once those four bits are in, the block knows whether the frame is a conversion request, a configuration access or nothing it handles.

A 12-bit configuration word sets the reference source, the output number format, the sample window length, the conversion clock divider, and the input, mode, sequence, end-flag and trigger fields. The core consumes these fields. A conversion opcode opens a sampling window as soon as its fourth bit has arrived. The window then counts 12 or 24 rising serial clock edges. When it closes, the block takes the 10-bit code from the converter stub and formats it as the result. The response to each frame is loaded when select falls. It is the configuration word if the previous complete frame was a permitted read, and the left-justified result otherwise.

Top module: `sdc_frontend`

## Requirements
- R1: After reset, cfg_word, every decoded field, sampling, result_word, conv_clk_en and sdo are all 0.
- R2: A complete 16-bit frame whose bits 15:12 are 0xA loads bits 11:0 into cfg_word on its 16th rising edge. The field positions are: 11 reference internal, 10 two's complement, 9 long sample, 8 half conversion clock, 7 pseudo-differential, 6:5 mode, 4:3 sweep sequence, 2 end-flag select, 1:0 trigger level. Each decoded output port equals its field.
- R3: A frame may pause with the serial clock idle and select held low, for example after 8 bits. It completes with the same effect once clocking resumes.
- R4: Select going high resets the bit position. A frame cut short by select has no effect, and the next frame is taken from its first bit. Rising edges beyond the 16th in one frame are ignored.
- R5: After a complete frame with opcode 0x9 that starts while bits 6:5 of the configuration are 00, the next frame shifts out {0000, cfg_word} MSB first.
- R6: An opcode 0x9 frame that starts while bits 6:5 are not 00 is not honoured. The next frame shifts out the result response of R11.
- R7: Opcodes 0x0 to 0x7 and 0xB to 0xD raise sampling right after the fourth rising edge of the frame. Opcodes 0x8, 0x9, 0xA, 0xE and 0xF never raise it.
- R8: Once open, sampling stays high for exactly 12 further rising edges when bit 9 is 0, and for 24 when bit 9 is 1. The count may run across frame boundaries. A new conversion opcode restarts the count.
- R9: When the window closes, result_word takes conv_code. If bit 10 is 1, the most significant bit of the code is inverted.
- R10: While select is low, conv_clk_en pulses once for every rising serial clock edge when bit 8 is 0. When bit 8 is 1 it pulses on the 2nd, 4th, and so on of the frame.
- R11: Unless R5 applies, a frame shifts out {result_word, 000000}. The word is loaded when select falls, and sdo advances only after falling serial clock edges.
- R12: Opcodes 0x8, 0xE and 0xF leave the configuration and sampling unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, MSB first |
| conv_code | input | 10 | Code delivered by the converter stub |
| cfg_word | output | 12 | Configuration register |
| ref_internal | output | 1 | Internal reference chosen |
| twos_comp | output | 1 | Two's complement output format |
| long_sample | output | 1 | 24-clock sample window |
| half_conv_clk | output | 1 | Conversion clock is half the serial clock |
| pseudo_diff | output | 1 | Pseudo-differential input |
| conv_mode | output | 2 | Conversion mode field |
| sweep_seq | output | 2 | Sweep sequence field |
| eoc_sel | output | 1 | End-of-conversion flag select |
| fifo_trig | output | 2 | Trigger level field |
| sampling | output | 1 | Sampling window active |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| result_word | output | 10 | Formatted conversion result |

## Verification
The bench probes the sampling line one edge before and one edge after the end of each window. A window that is one clock too long or too short, or that is tied to the frame instead of to the edge count, shows up there. A 24-edge window has to survive into the following frame. A design that closes the window when select rises fails that case. Read-back is tried under every mode value. A missing mode gate would return the configuration where the result belongs. A configuration write is paused mid-frame and another is cut short by select. A counter that misses edges or does not clear on select would store a shifted word. The bench checks the format inversion and the half-rate enable count, and both catch a wrong field bit.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 4;
  localparam int CFG_BITS   = 12;
  localparam int CODE_BITS  = 10;

  // configuration field positions
  localparam int F_REF     = 11;
  localparam int F_FMT     = 10;
  localparam int F_LONG    = 9;
  localparam int F_HALF    = 8;
  localparam int F_PDIFF   = 7;
  localparam int F_MODE_HI = 6;
  localparam int F_MODE_LO = 5;
  localparam int F_SEQ_HI  = 4;
  localparam int F_SEQ_LO  = 3;
  localparam int F_EOC     = 2;
  localparam int F_TRIG_HI = 1;
  localparam int F_TRIG_LO = 0;

  localparam logic [CMD_BITS-1:0] OP_CFG_RD = 4'h9;
  localparam logic [CMD_BITS-1:0] OP_CFG_WR = 4'hA;
  localparam logic [CMD_BITS-1:0] OP_TST_LO = 4'hB;
  localparam logic [CMD_BITS-1:0] OP_TST_HI = 4'hD;
  localparam logic [CMD_BITS-1:0] OP_CH_HI  = 4'h7;

  function automatic logic is_conv_op(input logic [CMD_BITS-1:0] op);
    return (op <= OP_CH_HI) || ((op >= OP_TST_LO) && (op <= OP_TST_HI));
  endfunction

  function automatic logic [CODE_BITS-1:0] fmt_code(input logic [CODE_BITS-1:0] code,
                                                    input logic twos);
    logic [CODE_BITS-1:0] r;
    r = code;
    if (twos) r[CODE_BITS-1] = ~code[CODE_BITS-1];
    return r;
  endfunction
endpackage

// File: rtl/sdc_sync.sv
`timescale 1ns/1ps
module sdc_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= din;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdc_shifter.sv
`timescale 1ns/1ps
module sdc_shifter import sdc_pkg::*; #(
  parameter int FRAME_W = FRAME_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               sdi_s,
  input  logic               half_div,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic               frame_load,
  output logic               nib_stb,
  output logic [CMD_BITS-1:0] nib_val,
  output logic               frm_stb,
  output logic [FRAME_W-1:0] frm_word,
  output logic               conv_clk_en,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] NIB_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FRM_FULL = CNT_W'(FRAME_W);

  logic               sclk_d_q, cs_d_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               phase_q, phase_d;
  logic               nib_q, nib_d;
  logic               frm_q, frm_d;
  logic               cen_q, cen_d;
  logic               active;

  assign sclk_rise  = sclk_s & ~sclk_d_q;
  assign sclk_fall  = ~sclk_s & sclk_d_q;
  assign frame_load = cs_d_q & ~cs_n_s;
  assign active     = ~cs_n_s;

  always_comb begin
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    phase_d = phase_q;
    nib_d   = 1'b0;
    frm_d   = 1'b0;
    cen_d   = 1'b0;
    if (!active) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (sclk_rise) begin
      cen_d   = ~half_div | phase_q;
      phase_d = ~phase_q;
      if (cnt_q != FRM_FULL) begin
        rx_d  = {rx_q[FRAME_W-2:0], sdi_s};
        cnt_d = cnt_q + 1'b1;
        nib_d = (cnt_q == NIB_LAST);
        frm_d = (cnt_q == FRM_LAST);
      end
    end
    if (frame_load) begin
      tx_d = tx_word;
    end else if (active && sclk_fall) begin
      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      phase_q  <= 1'b0;
      nib_q    <= 1'b0;
      frm_q    <= 1'b0;
      cen_q    <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_n_s;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      phase_q  <= phase_d;
      nib_q    <= nib_d;
      frm_q    <= frm_d;
      cen_q    <= cen_d;
    end
  end

  assign nib_stb     = nib_q;
  assign nib_val     = rx_q[CMD_BITS-1:0];
  assign frm_stb     = frm_q;
  assign frm_word    = rx_q;
  assign conv_clk_en = cen_q;
  assign sdo         = tx_q[FRAME_W-1];
endmodule

// File: rtl/sdc_cmd_cfg.sv
`timescale 1ns/1ps
module sdc_cmd_cfg import sdc_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nib_stb,
  input  logic [CMD_BITS-1:0]   nib_val,
  input  logic                  frm_stb,
  input  logic [FRAME_BITS-1:0] frm_word,
  input  logic                  frame_load,
  input  logic [CODE_BITS-1:0]  result_word,
  output logic [CFG_BITS-1:0]   cfg_q,
  output logic                  conv_start,
  output logic [FRAME_BITS-1:0] tx_word
);
  localparam int PAD_CFG  = FRAME_BITS - CFG_BITS;
  localparam int PAD_CODE = FRAME_BITS - CODE_BITS;

  logic [CFG_BITS-1:0] cfg_d;
  logic                rd_sel_q, rd_sel_d;
  logic [CMD_BITS-1:0] op;
  logic                mode_oneshot;

  assign op           = frm_word[FRAME_BITS-1 -: CMD_BITS];
  assign mode_oneshot = (cfg_q[F_MODE_HI:F_MODE_LO] == 2'b00);

  always_comb begin
    cfg_d    = cfg_q;
    rd_sel_d = rd_sel_q;
    if (frm_stb) begin
      if (op == OP_CFG_WR) cfg_d = frm_word[CFG_BITS-1:0];
      rd_sel_d = (op == OP_CFG_RD) && mode_oneshot;
    end else if (frame_load) begin
      rd_sel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      rd_sel_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      rd_sel_q <= rd_sel_d;
    end
  end

  assign conv_start = nib_stb & is_conv_op(nib_val);
  assign tx_word    = rd_sel_q ? {{PAD_CFG{1'b0}}, cfg_q}
                               : {result_word, {PAD_CODE{1'b0}}};
endmodule

// File: rtl/sdc_sample.sv
`timescale 1ns/1ps
module sdc_sample import sdc_pkg::*; #(
  parameter int SHORT_CLKS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_rise,
  input  logic                 conv_start,
  input  logic                 long_sel,
  input  logic                 twos,
  input  logic [CODE_BITS-1:0] conv_code,
  output logic                 sampling,
  output logic [CODE_BITS-1:0] result_word
);
  localparam int LONG_CLKS = 2 * SHORT_CLKS;
  localparam int CNT_W     = $clog2(LONG_CLKS);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_CLKS - 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_CLKS - 1);

  logic                 open_q, open_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CNT_W-1:0]     lim_q, lim_d;
  logic [CODE_BITS-1:0] res_q, res_d;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    res_d  = res_q;
    if (conv_start) begin
      open_d = 1'b1;
      cnt_d  = '0;
      lim_d  = long_sel ? LIM_LONG : LIM_SHORT;
    end else if (open_q && sclk_rise) begin
      if (cnt_q == lim_q) begin
        open_d = 1'b0;
        res_d  = fmt_code(conv_code, twos);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= LIM_SHORT;
      res_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      res_q  <= res_d;
    end
  end

  assign sampling    = open_q;
  assign result_word = res_q;
endmodule

// File: rtl/sdc_frontend.sv
`timescale 1ns/1ps
module sdc_frontend import sdc_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CLKS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic [CODE_BITS-1:0] conv_code,
  output logic [CFG_BITS-1:0]  cfg_word,
  output logic                 ref_internal,
  output logic                 twos_comp,
  output logic                 long_sample,
  output logic                 half_conv_clk,
  output logic                 pseudo_diff,
  output logic [1:0]           conv_mode,
  output logic [1:0]           sweep_seq,
  output logic                 eoc_sel,
  output logic [1:0]           fifo_trig,
  output logic                 sampling,
  output logic                 conv_clk_en,
  output logic [CODE_BITS-1:0] result_word
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, sdi_s;

  sdc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({sclk, cs_n, sdi}),
    .dout  (pins_s)
  );
  assign {sclk_s, cs_n_s, sdi_s} = pins_s;

  logic                  sclk_rise, sclk_fall, frame_load;
  logic                  nib_stb, frm_stb, conv_start;
  logic [CMD_BITS-1:0]   nib_val;
  logic [FRAME_BITS-1:0] frm_word, tx_word;
  logic [CFG_BITS-1:0]   cfg_q;

  sdc_shifter #(.FRAME_W(FRAME_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sclk_s      (sclk_s),
    .cs_n_s      (cs_n_s),
    .sdi_s       (sdi_s),
    .half_div    (cfg_q[F_HALF]),
    .tx_word     (tx_word),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .frame_load  (frame_load),
    .nib_stb     (nib_stb),
    .nib_val     (nib_val),
    .frm_stb     (frm_stb),
    .frm_word    (frm_word),
    .conv_clk_en (conv_clk_en),
    .sdo         (sdo)
  );

  sdc_cmd_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .nib_stb     (nib_stb),
    .nib_val     (nib_val),
    .frm_stb     (frm_stb),
    .frm_word    (frm_word),
    .frame_load  (frame_load),
    .result_word (result_word),
    .cfg_q       (cfg_q),
    .conv_start  (conv_start),
    .tx_word     (tx_word)
  );

  sdc_sample #(.SHORT_CLKS(SHORT_CLKS)) u_sample (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sclk_rise   (sclk_rise),
    .conv_start  (conv_start),
    .long_sel    (cfg_q[F_LONG]),
    .twos        (cfg_q[F_FMT]),
    .conv_code   (conv_code),
    .sampling    (sampling),
    .result_word (result_word)
  );

  assign cfg_word      = cfg_q;
  assign ref_internal  = cfg_q[F_REF];
  assign twos_comp     = cfg_q[F_FMT];
  assign long_sample   = cfg_q[F_LONG];
  assign half_conv_clk = cfg_q[F_HALF];
  assign pseudo_diff   = cfg_q[F_PDIFF];
  assign conv_mode     = cfg_q[F_MODE_HI:F_MODE_LO];
  assign sweep_seq     = cfg_q[F_SEQ_HI:F_SEQ_LO];
  assign eoc_sel       = cfg_q[F_EOC];
  assign fifo_trig     = cfg_q[F_TRIG_HI:F_TRIG_LO];
endmodule

// File: rtl/sdc_frontend_chk.sv
`timescale 1ns/1ps
module sdc_frontend_chk import sdc_pkg::*; #(
  parameter int SHORT_CLKS = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sclk_rise,
  input logic                  sclk_fall,
  input logic                  frame_load,
  input logic                  cs_n_s,
  input logic                  nib_stb,
  input logic [CMD_BITS-1:0]   nib_val,
  input logic                  frm_stb,
  input logic [FRAME_BITS-1:0] frm_word,
  input logic [CFG_BITS-1:0]   cfg_word,
  input logic                  sampling,
  input logic [CODE_BITS-1:0]  result_word,
  input logic                  conv_clk_en,
  input logic                  sdo
);
  localparam int LONG_CLKS = 2 * SHORT_CLKS;
  localparam int CW        = $clog2(LONG_CLKS + 2);

  logic [CW-1:0] win_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               win_cnt_q <= '0;
    else if (nib_stb && is_conv_op(nib_val))  win_cnt_q <= '0;
    else if (sampling && sclk_rise)           win_cnt_q <= win_cnt_q + 1'b1;
  end

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(frm_stb && (frm_word[FRAME_BITS-1 -: CMD_BITS] == OP_CFG_WR)));

  p_open_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sampling) |-> $past(nib_stb && is_conv_op(nib_val)));

  p_window_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> (win_cnt_q <= CW'(LONG_CLKS)));

  p_result_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_word) |-> $fell(sampling));

  p_conv_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_clk_en |-> $past(sclk_rise && !cs_n_s));

  p_sdo_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall || frame_load));
endmodule

bind sdc_frontend sdc_frontend_chk #(.SHORT_CLKS(SHORT_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .frame_load  (frame_load),
  .cs_n_s      (cs_n_s),
  .nib_stb     (nib_stb),
  .nib_val     (nib_val),
  .frm_stb     (frm_stb),
  .frm_word    (frm_word),
  .cfg_word    (cfg_word),
  .sampling    (sampling),
  .result_word (result_word),
  .conv_clk_en (conv_clk_en),
  .sdo         (sdo)
);

// File: tb/sdc_frontend_tb.sv
`timescale 1ns/1ps
module sdc_frontend_tb;
  localparam int HALF = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, sclk, cs_n, sdi, sdo;
  logic [9:0]  conv_code;
  logic [11:0] cfg_word;
  logic        ref_internal, twos_comp, long_sample, half_conv_clk, pseudo_diff;
  logic [1:0]  conv_mode, sweep_seq, fifo_trig;
  logic        eoc_sel, sampling, conv_clk_en;
  logic [9:0]  result_word;

  sdc_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .conv_code(conv_code), .cfg_word(cfg_word), .ref_internal(ref_internal),
    .twos_comp(twos_comp), .long_sample(long_sample), .half_conv_clk(half_conv_clk),
    .pseudo_diff(pseudo_diff), .conv_mode(conv_mode), .sweep_seq(sweep_seq),
    .eoc_sel(eoc_sel), .fifo_trig(fifo_trig), .sampling(sampling),
    .conv_clk_en(conv_clk_en), .result_word(result_word)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          pulse_total = 0;
  bit          done = 1'b0;
  logic [15:0] rd_word;
  logic [11:0] exp_cfg;
  logic [9:0]  exp_res;

  always @(negedge clk) if (conv_clk_en) pulse_total++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_start;
    cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic cs_end;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic send_bits(input logic [15:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      sdi = w[i];
      wait_clk(HALF);
      rd_word[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [15:0] w);
    cs_start;
    send_bits(w, 15, 0);
    cs_end;
  endtask

  function automatic logic [9:0] fmt(input logic [9:0] c, input logic tw);
    return tw ? (c ^ 10'h200) : c;
  endfunction

  function automatic logic [3:0] pick_conv(input int r);
    return (r < 8) ? 4'(r) : 4'(r + 3);
  endfunction

  task automatic write_cfg(input logic [11:0] v, input string req);
    frame({4'hA, v});
    exp_cfg = v;
    check(cfg_word == v, req, cfg_word, v);
  endtask

  // conversion frame plus any closing frame; checks R7, R8, R9, R10
  task automatic convert(input logic [3:0] op);
    int start;
    logic lng;
    lng = exp_cfg[9];
    start = pulse_total;
    cs_start;
    send_bits({op, 12'h000}, 15, 12);
    check(sampling == 1'b1, "R7 open after nibble", sampling, 1);
    send_bits({op, 12'h000}, 11, 1);
    check(sampling == 1'b1, "R8 open one edge before short end", sampling, 1);
    send_bits({op, 12'h000}, 0, 0);
    cs_end;
    check((pulse_total - start) == (exp_cfg[8] ? 8 : 16), "R10 enable count",
          pulse_total - start, exp_cfg[8] ? 8 : 16);
    if (!lng) begin
      check(sampling == 1'b0, "R8 short window closed", sampling, 0);
    end else begin
      check(sampling == 1'b1, "R8 long window spans frame", sampling, 1);
      cs_start;
      send_bits(16'hF000, 15, 5);
      check(sampling == 1'b1, "R8 long window one edge before end", sampling, 1);
      send_bits(16'hF000, 4, 0);
      cs_end;
      check(sampling == 1'b0, "R8 long window closed", sampling, 0);
    end
    exp_res = fmt(conv_code, exp_cfg[10]);
    check(result_word == exp_res, "R9 result format", result_word, exp_res);
  endtask

  initial begin
    int r;
    logic [15:0] exp_w;
    logic [3:0]  ign;
    void'($urandom(32'h5DC0_1234));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; conv_code = '0;
    exp_cfg = '0; exp_res = '0; rd_word = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1
    check(cfg_word == 12'h000 && sampling == 1'b0 && result_word == 10'h000 && sdo == 1'b0
          && conv_clk_en == 1'b0 && conv_mode == 2'b00, "R1 reset state", cfg_word, 0);

    // R2: fields and decoded ports
    write_cfg(12'hA5A, "R2 write");
    check({ref_internal, twos_comp, long_sample, half_conv_clk, pseudo_diff, conv_mode,
           sweep_seq, eoc_sel, fifo_trig} == 12'hA5A, "R2 decoded fields",
          {ref_internal, twos_comp, long_sample, half_conv_clk, pseudo_diff, conv_mode,
           sweep_seq, eoc_sel, fifo_trig}, 12'hA5A);

    // R3: pause after 8 bits
    cs_start;
    send_bits(16'hA3C1, 15, 8);
    wait_clk(300);
    check(cfg_word == exp_cfg, "R3 no write during pause", cfg_word, exp_cfg);
    send_bits(16'hA3C1, 7, 0);
    cs_end;
    exp_cfg = 12'h3C1;
    check(cfg_word == 12'h3C1, "R3 paused write completes", cfg_word, 12'h3C1);

    // R4: aborted frame then aligned frame; extra edges ignored
    cs_start;
    send_bits(16'hAFFF, 15, 8);
    cs_end;
    check(cfg_word == exp_cfg, "R4 aborted frame no effect", cfg_word, exp_cfg);
    cs_start;
    send_bits(16'hA012, 15, 0);
    send_bits(16'hFFFF, 15, 12);
    cs_end;
    exp_cfg = 12'h012;
    check(cfg_word == 12'h012, "R4 realigned and extra edges ignored", cfg_word, 12'h012);

    // R12: ignored opcodes
    foreach (ign[k]) begin end
    for (int k = 0; k < 3; k++) begin
      ign = (k == 0) ? 4'h8 : (k == 1) ? 4'hE : 4'hF;
      cs_start;
      send_bits({ign, 12'hFFF}, 15, 12);
      check(sampling == 1'b0, "R12 ignored opcode no sampling", sampling, 0);
      send_bits({ign, 12'hFFF}, 11, 0);
      cs_end;
      check(cfg_word == exp_cfg, "R12 ignored opcode keeps cfg", cfg_word, exp_cfg);
    end

    // R5: read-back in one-shot mode
    write_cfg(12'h81C, "R2 write");
    frame(16'h9000);
    frame(16'hF000);
    exp_w = {4'h0, exp_cfg};
    check(rd_word == exp_w, "R5 read-back word", rd_word, exp_w);

    // R6: read blocked by mode; R11 result response
    write_cfg(12'h060, "R2 write");
    conv_code = 10'h2B7;
    convert(4'h3);
    frame(16'h9000);
    exp_w = {exp_res, 6'b0};
    check(rd_word == exp_w, "R11 result response", rd_word, exp_w);
    frame(16'hF000);
    check(rd_word == exp_w, "R6 gated read returns result", rd_word, exp_w);

    // directed: twos complement of zero and all-ones, long window
    write_cfg(12'h600, "R2 write");
    conv_code = 10'h000;
    convert(4'hC);
    conv_code = 10'h3FF;
    convert(4'h0);

    // random section
    for (int it = 0; it < 24; it++) begin
      write_cfg(12'($urandom), "R2 write random");
      conv_code = 10'($urandom);
      r = int'($urandom % 11);
      convert(pick_conv(r));
      r = int'($urandom % 3);
      ign = (r == 0) ? 4'h8 : (r == 1) ? 4'hE : 4'hF;
      cs_start;
      send_bits({ign, 12'($urandom)}, 15, 12);
      check(sampling == 1'b0, "R7 no open for other opcode", sampling, 0);
      send_bits({ign, 12'h000}, 11, 0);
      cs_end;
      frame(16'h9000);
      exp_w = {exp_res, 6'b0};
      check(rd_word == exp_w, "R11 result response", rd_word, exp_w);
      frame(16'hF000);
      exp_w = (exp_cfg[6:5] == 2'b00) ? {4'h0, exp_cfg} : {exp_res, 6'b0};
      check(rd_word == exp_w, (exp_cfg[6:5] == 2'b00) ? "R5 read-back" : "R6 gated read",
            rd_word, exp_w);
      check(cfg_word == exp_cfg, "R12 cfg held", cfg_word, exp_cfg);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule